// File: doc/BRIEF.md
# Serial Clock and Select Timing Generator

This block produces the serial clock and the select strobe for a serial flash port. All of its timing is counted in system clock cycles. A requester hands over a pulse count on a valid/ready start channel. The block then asserts the select line and waits a coded lead delay. It emits the requested number of serial clock pulses, whose high and low phases have separately programmed lengths. After the last pulse it holds select for a coded trail delay and then releases it.

The clock mode input chooses between two legal idle levels: low (mode 0) or high (mode 3). In both modes data is sampled on the rising edge. Two one-cycle strobes tell a neighbouring shifter when to move the next bit out (falling edge) and when to capture the incoming bit (rising edge). A busy level spans the whole transaction, and a done pulse marks its end.

The start channel follows valid/ready rules:
- `req_ready` is high exactly when the block is idle.
- A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- A requester that sees `req_ready` low must hold `req_valid` and `req_count` steady until the handshake completes.

Configuration inputs are plain levels and are captured at the handshake.

Top module: `sst_clk_timer`

## Requirements
- R1: `req_ready` is high if and only if the block is idle. A request is accepted only on an edge with `req_valid` and `req_ready` both high. A request held while busy is not taken until the cycle after done.
- R2: Select is asserted from the cycle after acceptance for exactly lead + N·(high + low) + trail cycles. Its active level is high when `cfg_sel_pol`=0 and low when `cfg_sel_pol`=1. While idle, it sits at the inactive level, which equals `cfg_sel_pol`.
- R3: Lead code 0, 1, 2, 3 gives 0, 2, 4, 8 cycles from the start of select to the first clock edge. With lead 0, the first edge appears in the same cycle as select.
- R4: Trail code 0, 1, 2, 3 gives 1, 3, 5, 9 cycles of select after the final clock phase ends.
- R5: The high phase lasts `cfg_hi_len` cycles and the low phase lasts `cfg_lo_len` cycles. A value of 0 counts as 1 cycle.
- R6: With `cfg_mode3`=0, SCLK idles low and each pulse is its high phase followed by its low phase. With `cfg_mode3`=1, SCLK idles high and each pulse is its low phase followed by its high phase. While idle, SCLK follows `cfg_mode3`.
- R7: `sample_stb` is high only in the first cycle of each SCLK high phase. `shift_stb` is high only in the first cycle of each SCLK low phase. Each strobe lasts one cycle, and the two are never high together.
- R8: `busy` is high in every cycle where select is asserted. `done` is a one-cycle pulse in the first cycle after select is released, with `busy` low in that cycle. Reset leaves the block idle.
- R9: The configuration inputs and `req_count` are captured at acceptance. Changing them during a transaction has no effect on it.
- R10: A pulse count of 0 asserts select for lead + trail cycles with no SCLK edge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode3 | input | 1 | 0: clock mode 0 (idle low), 1: clock mode 3 (idle high) |
| cfg_sel_pol | input | 1 | 0: select active high, 1: select active low |
| cfg_hi_len | input | LEN_W | High phase length in cycles (0 counts as 1) |
| cfg_lo_len | input | LEN_W | Low phase length in cycles (0 counts as 1) |
| cfg_lead_code | input | 2 | Lead delay code: 0, 2, 4 or 8 cycles |
| cfg_trail_code | input | 2 | Trail delay code: 1, 3, 5 or 9 cycles |
| req_valid | input | 1 | Start request valid |
| req_ready | output | 1 | Start request ready (block idle) |
| req_count | input | CNT_W | Number of SCLK pulses to emit |
| sclk | output | 1 | Serial clock |
| csel | output | 1 | Select line |
| shift_stb | output | 1 | One-cycle strobe at each falling SCLK edge |
| sample_stb | output | 1 | One-cycle strobe at each rising SCLK edge |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench builds the block with CNT_W=4 and LEN_W=4. At these widths, the largest pulse count (15) and the largest phase length (15) are cheap to reach, so the bench runs the count and length limits next to the zero-length and zero-count cases. Its behavioural model is driven from lookup lists of lead and trail cycle counts. It covers both clock modes, both select polarities and every lead and trail code. It also covers configuration changes in the middle of a transaction and a request held high across a busy period.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PH1,
    ST_PH2,
    ST_TRAIL
  } sst_state_e;

  // Lead delay: code 0 -> 0 cycles, otherwise 2^code cycles
  function automatic logic [3:0] lead_cycles(input logic [1:0] code);
    return (code == 2'd0) ? 4'd0 : (4'd1 << code);
  endfunction

  // Trail delay: code 0 -> 1 cycle, otherwise 2^code + 1 cycles
  function automatic logic [3:0] trail_cycles(input logic [1:0] code);
    return (code == 2'd0) ? 4'd1 : ((4'd1 << code) + 4'd1);
  endfunction

endpackage

// File: rtl/sst_phase_timer.sv
module sst_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);

  logic [W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign expire = (rem_q == '0);

  // R5
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rem_q == $past(load_val)));

endmodule

// File: rtl/sst_cfg_capture.sv
module sst_cfg_capture
  import sst_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mode3,
  input  logic             sel_pol,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [1:0]       lead_code,
  input  logic [1:0]       trail_code,
  input  logic [CNT_W-1:0] count,
  output logic             q_mode3,
  output logic             q_sel_pol,
  output logic [LEN_W-1:0] eff_len1,
  output logic [LEN_W-1:0] eff_len2,
  output logic [3:0]       eff_lead,
  output logic [3:0]       eff_trail,
  output logic [CNT_W-1:0] eff_count
);

  logic [LEN_W-1:0] hi_fix, lo_fix, live_len1, live_len2;
  logic [LEN_W-1:0] len1_q, len2_q;
  logic [3:0]       lead_q, trail_q;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    hi_fix    = (hi_len == '0) ? LEN_W'(1) : hi_len;
    lo_fix    = (lo_len == '0) ? LEN_W'(1) : lo_len;
    live_len1 = mode3 ? lo_fix : hi_fix;
    live_len2 = mode3 ? hi_fix : lo_fix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mode3   <= 1'b0;
      q_sel_pol <= 1'b0;
      len1_q    <= LEN_W'(1);
      len2_q    <= LEN_W'(1);
      lead_q    <= 4'd0;
      trail_q   <= 4'd1;
      count_q   <= '0;
    end else if (load) begin
      q_mode3   <= mode3;
      q_sel_pol <= sel_pol;
      len1_q    <= live_len1;
      len2_q    <= live_len2;
      lead_q    <= lead_cycles(lead_code);
      trail_q   <= trail_cycles(trail_code);
      count_q   <= count;
    end
  end

  // Bypass so the sequencer can branch in the accepting cycle
  assign eff_len1  = load ? live_len1 : len1_q;
  assign eff_len2  = load ? live_len2 : len2_q;
  assign eff_lead  = load ? lead_cycles(lead_code) : lead_q;
  assign eff_trail = load ? trail_cycles(trail_code) : trail_q;
  assign eff_count = load ? count : count_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(q_mode3) && $stable(q_sel_pol) && $stable(count_q)));

endmodule

// File: rtl/sst_seq.sv
module sst_seq
  import sst_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len1,
  input  logic [LEN_W-1:0] len2,
  input  logic [3:0]       lead,
  input  logic [3:0]       trail,
  input  logic [CNT_W-1:0] count,
  output logic             tog,
  output logic             ph1_stb,
  output logic             ph2_stb,
  output logic             busy,
  output logic             done
);

  sst_state_e       state_q, state_n;
  logic [CNT_W-1:0] left_q, left_n;
  logic             tog_n, s1_n, s2_n, done_n;
  logic             ld;
  logic [LEN_W-1:0] ld_val;
  logic             expire;

  sst_phase_timer #(.W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .expire   (expire)
  );

  always_comb begin
    state_n = state_q;
    left_n  = left_q;
    tog_n   = tog;
    s1_n    = 1'b0;
    s2_n    = 1'b0;
    done_n  = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          left_n = count;
          ld     = 1'b1;
          if (lead != 4'd0) begin
            state_n = ST_LEAD;
            ld_val  = LEN_W'(lead - 4'd1);
          end else if (count != '0) begin
            state_n = ST_PH1;
            tog_n   = 1'b1;
            s1_n    = 1'b1;
            ld_val  = len1 - 1'b1;
          end else begin
            state_n = ST_TRAIL;
            ld_val  = LEN_W'(trail - 4'd1);
          end
        end
      end
      ST_LEAD: begin
        if (expire) begin
          ld = 1'b1;
          if (left_q != '0) begin
            state_n = ST_PH1;
            tog_n   = 1'b1;
            s1_n    = 1'b1;
            ld_val  = len1 - 1'b1;
          end else begin
            state_n = ST_TRAIL;
            ld_val  = LEN_W'(trail - 4'd1);
          end
        end
      end
      ST_PH1: begin
        if (expire) begin
          state_n = ST_PH2;
          tog_n   = 1'b0;
          s2_n    = 1'b1;
          ld      = 1'b1;
          ld_val  = len2 - 1'b1;
        end
      end
      ST_PH2: begin
        if (expire) begin
          ld = 1'b1;
          if (left_q > CNT_W'(1)) begin
            left_n  = left_q - 1'b1;
            state_n = ST_PH1;
            tog_n   = 1'b1;
            s1_n    = 1'b1;
            ld_val  = len1 - 1'b1;
          end else begin
            state_n = ST_TRAIL;
            ld_val  = LEN_W'(trail - 4'd1);
          end
        end
      end
      ST_TRAIL: begin
        if (expire) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      tog     <= 1'b0;
      ph1_stb <= 1'b0;
      ph2_stb <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      left_q  <= left_n;
      tog     <= tog_n;
      ph1_stb <= s1_n;
      ph2_stb <= s2_n;
      done    <= done_n;
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R10
  no_pulse_without_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PH1) |-> (left_q != '0));

  // R8
  done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == ST_IDLE));

  // R4
  trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAIL) |-> !tog);

endmodule

// File: rtl/sst_clk_timer.sv
module sst_clk_timer #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode3,
  input  logic             cfg_sel_pol,
  input  logic [LEN_W-1:0] cfg_hi_len,
  input  logic [LEN_W-1:0] cfg_lo_len,
  input  logic [1:0]       cfg_lead_code,
  input  logic [1:0]       cfg_trail_code,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  output logic             sclk,
  output logic             csel,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             busy,
  output logic             done
);

  logic             accept;
  logic             q_mode3, q_sel_pol;
  logic [LEN_W-1:0] len1, len2;
  logic [3:0]       lead, trail;
  logic [CNT_W-1:0] count;
  logic             tog, ph1_stb, ph2_stb;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  sst_cfg_capture #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .mode3      (cfg_mode3),
    .sel_pol    (cfg_sel_pol),
    .hi_len     (cfg_hi_len),
    .lo_len     (cfg_lo_len),
    .lead_code  (cfg_lead_code),
    .trail_code (cfg_trail_code),
    .count      (req_count),
    .q_mode3    (q_mode3),
    .q_sel_pol  (q_sel_pol),
    .eff_len1   (len1),
    .eff_len2   (len2),
    .eff_lead   (lead),
    .eff_trail  (trail),
    .eff_count  (count)
  );

  sst_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .len1    (len1),
    .len2    (len2),
    .lead    (lead),
    .trail   (trail),
    .count   (count),
    .tog     (tog),
    .ph1_stb (ph1_stb),
    .ph2_stb (ph2_stb),
    .busy    (busy),
    .done    (done)
  );

  assign sclk       = busy ? (q_mode3 ^ tog) : cfg_mode3;
  assign csel       = busy ? ~q_sel_pol : cfg_sel_pol;
  assign sample_stb = q_mode3 ? ph2_stb : ph1_stb;
  assign shift_stb  = q_mode3 ? ph1_stb : ph2_stb;

  // R1
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R2
  sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(csel));

  // R7
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sclk && busy));

  // R7
  shift_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (!sclk && busy));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/sst_clk_timer_bench.sv
module sst_clk_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int LEN_W      = 4;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_mode3 = 1'b0;
  logic             cfg_sel_pol = 1'b0;
  logic [LEN_W-1:0] cfg_hi_len = '0;
  logic [LEN_W-1:0] cfg_lo_len = '0;
  logic [1:0]       cfg_lead_code = '0;
  logic [1:0]       cfg_trail_code = '0;
  logic             req_valid = 1'b0;
  logic [CNT_W-1:0] req_count = '0;
  logic req_ready, sclk, csel, shift_stb, sample_stb, busy, done;

  sst_clk_timer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_sst_clk_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode3      (cfg_mode3),
    .cfg_sel_pol    (cfg_sel_pol),
    .cfg_hi_len     (cfg_hi_len),
    .cfg_lo_len     (cfg_lo_len),
    .cfg_lead_code  (cfg_lead_code),
    .cfg_trail_code (cfg_trail_code),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_count      (req_count),
    .sclk           (sclk),
    .csel           (csel),
    .shift_stb      (shift_stb),
    .sample_stb     (sample_stb),
    .busy           (busy),
    .done           (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  bit    finished = 0;
  string tag      = "reset";

  // Reference model state
  int lead_tab[4]  = '{0, 2, 4, 8};
  int trail_tab[4] = '{1, 3, 5, 9};
  int c = 0, m_end = 0, mL = 0, mT = 0, mP1 = 1, mP2 = 1, mN = 0;
  bit mm = 0, mp = 0, m_done = 0;

  task automatic chk(input logic act, input logic exp, input string name, input string rq);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s at cycle %0d actual=%0b expected=%0b", rq, tag, name, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired at cycle %0d actual=running expected=finished", cyc);
      report();
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      c = 0;
      m_done = 0;
    end else begin
      m_done = 0;
      if (c > 0) begin
        if (c == m_end) begin
          c = 0;
          m_done = 1;
        end else begin
          c = c + 1;
        end
      end else if (req_valid) begin
        mm  = cfg_mode3;
        mp  = cfg_sel_pol;
        mP1 = mm ? ((cfg_lo_len == 0) ? 1 : int'(cfg_lo_len)) : ((cfg_hi_len == 0) ? 1 : int'(cfg_hi_len));
        mP2 = mm ? ((cfg_hi_len == 0) ? 1 : int'(cfg_hi_len)) : ((cfg_lo_len == 0) ? 1 : int'(cfg_lo_len));
        mL  = lead_tab[cfg_lead_code];
        mT  = trail_tab[cfg_trail_code];
        mN  = int'(req_count);
        m_end = mL + mN * (mP1 + mP2) + mT;
        c = 1;
      end
    end
  end

  always @(negedge clk) begin
    bit e_sclk, e_sel, e_smp, e_shf, tg, s1, s2;
    int k, p;
    if (!rst_n) begin
      chk(busy, 1'b0, "busy", "R8");
      chk(done, 1'b0, "done", "R8");
      chk(req_ready, 1'b1, "req_ready", "R1");
      chk(sample_stb | shift_stb, 1'b0, "strobes", "R7");
      chk(csel, cfg_sel_pol, "csel", "R2");
      chk(sclk, cfg_mode3, "sclk", "R6");
    end else begin
      tg = 0; s1 = 0; s2 = 0;
      if (c > 0) begin
        e_sel = ~mp;
        p = mP1 + mP2;
        if (c > mL && c <= mL + mN * p) begin
          k  = (c - mL - 1) % p;
          tg = (k < mP1);
          s1 = (k == 0);
          s2 = (k == mP1);
        end
        e_sclk = mm ^ tg;
        e_smp  = mm ? s2 : s1;
        e_shf  = mm ? s1 : s2;
      end else begin
        e_sel  = cfg_sel_pol;
        e_sclk = cfg_mode3;
        e_smp  = 0;
        e_shf  = 0;
      end
      chk(sclk, e_sclk, "sclk", "R6");
      chk(csel, e_sel, "csel", "R2");
      chk(sample_stb, e_smp, "sample_stb", "R7");
      chk(shift_stb, e_shf, "shift_stb", "R7");
      chk(busy, c > 0, "busy", "R8");
      chk(done, m_done, "done", "R8");
      chk(req_ready, c == 0, "req_ready", "R1");
    end
  end

  task automatic set_cfg(input bit m, input bit p, input int hi, input int lo,
                         input int ld, input int tr, input int n);
    cfg_mode3      = m;
    cfg_sel_pol    = p;
    cfg_hi_len     = LEN_W'(hi);
    cfg_lo_len     = LEN_W'(lo);
    cfg_lead_code  = 2'(ld);
    cfg_trail_code = 2'(tr);
    req_count      = CNT_W'(n);
  endtask

  task automatic wait_accept();
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_one(input bit m, input bit p, input int hi, input int lo,
                         input int ld, input int tr, input int n);
    @(posedge clk);
    #1;
    set_cfg(m, p, hi, lo, ld, tr, n);
    req_valid = 1'b1;
    wait_accept();
    req_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    tag = "R3 lead codes";
    for (int ld = 0; ld < 4; ld++) run_one(0, 0, 2, 3, ld, 0, 2);

    tag = "R4 trail codes";
    for (int tr = 0; tr < 4; tr++) run_one(0, 1, 1, 2, 1, tr, 1);

    tag = "R5 zero and max lengths";
    run_one(0, 0, 0, 0, 0, 0, 3);
    run_one(0, 0, 15, 1, 2, 1, 2);
    run_one(1, 0, 1, 15, 1, 2, 2);

    tag = "R6 mode 3";
    run_one(1, 1, 3, 2, 2, 1, 4);
    run_one(1, 0, 2, 4, 0, 3, 3);

    tag = "R10 zero count";
    run_one(0, 0, 2, 2, 0, 0, 0);
    run_one(1, 1, 2, 2, 3, 3, 0);

    tag = "R9 change while busy";
    @(posedge clk);
    #1;
    set_cfg(0, 0, 3, 2, 1, 1, 3);
    req_valid = 1'b1;
    wait_accept();
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    set_cfg(1, 1, 7, 0, 3, 3, 9);
    wait_idle();

    tag = "R1 request held while busy";
    @(posedge clk);
    #1;
    set_cfg(0, 1, 1, 1, 1, 0, 2);
    req_valid = 1'b1;
    wait_accept();
    req_count = CNT_W'(3);
    wait_accept();
    req_valid = 1'b0;
    wait_idle();

    tag = "R2 max count";
    run_one(0, 1, 1, 1, 0, 0, 15);

    repeat (5) @(negedge clk);
    report();
  end

endmodule